// File: doc/BRIEF.md
# Register Shadow Filter

This block sits on a stream of register-write commands, each an address and a data word, on its way to a downstream register file. It keeps a shadow copy of recent register values in a small internal store. A mode register, loaded by a command to a reserved address, decides what happens to each write. The write can be compared against the shadow and dropped when redundant, stored and always forwarded, passed through untouched, or replaced by the stored copy.

A local sequencer reads shadow values through a separate read port. That port returns what the shadow holds, not what the downstream register file holds. Both command streams use valid/ready handshakes, and a forwarded write leaves the block one cycle after it is accepted.

Top module: `regshadow_filter`

## Requirements
- R1: In filter mode (mode code 0), an accepted write is forwarded only when its data differs from the shadow entry. The shadow entry takes the new data in every case.
- R2: In track mode (mode code 1), every accepted write is forwarded unchanged and its data is stored in the shadow entry, even when the data equals the stored value.
- R3: In pass mode (mode code 2), every accepted write is forwarded unchanged and the shadow entry is not modified.
- R4: In replay mode (mode code 3), the incoming data is ignored. The write goes out with its own address and the stored shadow value, and the shadow entry is not modified.
- R5: `rd_data` presents the shadow entry selected by `rd_addr` one cycle after it is sampled. When a shadow write to the same entry happens in that cycle, it presents the value from before the write.
- R6: A command whose address equals `MODE_ADDR` loads the mode from data bits [1:0]. It is forwarded unchanged, is never filtered or replayed, does not touch the shadow, and the new mode governs the very next command.
- R7: `in_ready` is high whenever the output holds no beat or `out_ready` is high. An output beat appears one cycle after acceptance, is held stable while `out_ready` is low, and a suppressed write produces no beat.
- R8: Reset clears every shadow entry and `rd_data` to zero, sets the mode to filter, and leaves no output beat pending.
- R9: The shadow entry is selected by the low `IDX_W` (8) address bits, so addresses that share those bits share one entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Incoming command valid |
| in_ready | output | 1 | Block can accept a command |
| in_addr | input | ADDR_W (16) | Incoming register address |
| in_data | input | DATA_W (32) | Incoming register data |
| out_valid | output | 1 | Outgoing write valid |
| out_ready | input | 1 | Downstream can take the write |
| out_addr | output | ADDR_W (16) | Outgoing register address |
| out_data | output | DATA_W (32) | Outgoing register data |
| rd_addr | input | IDX_W (8) | Sequencer shadow read index |
| rd_data | output | DATA_W (32) | Shadow value, one cycle after `rd_addr` |

## Verification
The properties assume that the downstream side follows the handshake. They also assume that `in_addr` and `in_data` are meaningful only in cycles where `in_valid` and `in_ready` are both high, since every mode check is gated by that acceptance. The stimulus drives inputs only on falling edges and keeps a stalled command at the input until it is taken. The mode-register command is always issued as an ordinary accepted command, so each mode change is visible to the next accepted write.

// File: rtl/rsf_pkg.sv
// Shared types for the register shadow filter.
// Assumes the mode field is two bits wide and sits at data bits [1:0].
package rsf_pkg;
    typedef enum logic [1:0] {
        MODE_FILTER = 2'd0,
        MODE_TRACK  = 2'd1,
        MODE_PASS   = 2'd2,
        MODE_REPLAY = 2'd3
    } rsf_mode_e;
endpackage

// File: rtl/rsf_shadow_store.sv
// Shadow value store: one flop word per entry.
// Provides one write port, one combinational compare port and one registered
// sequencer read port. The registered read samples before a same-edge write,
// so it returns the old value.
module rsf_shadow_store #(
    parameter int IDX_W  = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  cmp_idx,
    output logic [DATA_W-1:0] cmp_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DATA_W-1:0] mem [DEPTH];

    for (genvar e = 0; e < DEPTH; e++) begin : g_entry
        // Clear on reset, load when the write port selects this entry.
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem[e] <= '0;
            else if (wr_en && (wr_idx == IDX_W'(e)))
                mem[e] <= wr_data;
        end
    end

    // Compare port used by the decision logic in the same cycle.
    assign cmp_data = mem[cmp_idx];

    // Registered sequencer read of the pre-write contents.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data <= '0;
        else
            rd_data <= mem[rd_idx];
    end
endmodule

// File: rtl/rsf_decide.sv
// Per-command decision: forward or drop, which data goes out, whether the
// shadow is written, and whether the mode register is loaded.
// Assumes old_val is the shadow entry for the command's index.
module rsf_decide #(
    parameter int DATA_W = 32
) (
    input  rsf_pkg::rsf_mode_e mode,
    input  logic               is_mode_cmd,
    input  logic [DATA_W-1:0]  in_data,
    input  logic [DATA_W-1:0]  old_val,
    output logic               fwd,
    output logic [DATA_W-1:0]  fwd_data,
    output logic               shadow_we,
    output logic               mode_we
);
    import rsf_pkg::*;

    // Mode-dependent handling; mode commands bypass every mode.
    always_comb begin
        fwd       = 1'b1;
        fwd_data  = in_data;
        shadow_we = 1'b0;
        mode_we   = 1'b0;
        if (is_mode_cmd) begin
            mode_we = 1'b1;
        end else begin
            unique case (mode)
                MODE_FILTER: begin
                    fwd       = (in_data != old_val);
                    shadow_we = 1'b1;
                end
                MODE_TRACK:  shadow_we = 1'b1;
                MODE_PASS:   shadow_we = 1'b0;
                MODE_REPLAY: fwd_data  = old_val;
                default:     fwd       = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/rsf_outreg.sv
// Output beat register with a valid/ready handshake.
// Holds a beat until the downstream takes it. Signals when a new beat may be
// loaded, so the upstream stalls while a beat is held.
module rsf_outreg #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [DATA_W-1:0] ld_data,
    input  logic              out_ready,
    output logic              can_accept,
    output logic              out_valid,
    output logic [ADDR_W-1:0] out_addr,
    output logic [DATA_W-1:0] out_data
);
    assign can_accept = !out_valid || out_ready;

    // Valid flag: set on load, cleared once the downstream takes the beat.
    always_ff @(posedge clk) begin
        if (!rst_n)
            out_valid <= 1'b0;
        else if (load)
            out_valid <= 1'b1;
        else if (out_ready)
            out_valid <= 1'b0;
    end

    // Payload: captured on load only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_addr <= '0;
            out_data <= '0;
        end else if (load) begin
            out_addr <= ld_addr;
            out_data <= ld_data;
        end
    end
endmodule

// File: rtl/regshadow_filter.sv
// Register shadow filter top level.
// Accepts register-write commands and applies the current mode against the
// shadow store. Forwards the resulting write with one cycle of latency and
// serves sequencer reads of the shadow.
// Assumes MODE_ADDR is not used for any ordinary register.
module regshadow_filter #(
    parameter int              ADDR_W    = 16,
    parameter int              DATA_W    = 32,
    parameter int              IDX_W     = 8,
    parameter logic [ADDR_W-1:0] MODE_ADDR = 16'hFF00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [ADDR_W-1:0] out_addr,
    output logic [DATA_W-1:0] out_data,
    input  logic [IDX_W-1:0]  rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    import rsf_pkg::*;

    rsf_mode_e         mode_q;
    logic              accept;
    logic              is_mode_cmd;
    logic [IDX_W-1:0]  cmd_idx;
    logic [DATA_W-1:0] old_val;
    logic              fwd;
    logic [DATA_W-1:0] fwd_data;
    logic              shadow_we;
    logic              mode_we;

    assign accept      = in_valid && in_ready;
    assign is_mode_cmd = (in_addr == MODE_ADDR);
    assign cmd_idx     = in_addr[IDX_W-1:0];

    // Mode register: loaded by an accepted mode command.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_q <= MODE_FILTER;
        else if (accept && mode_we)
            mode_q <= rsf_mode_e'(in_data[1:0]);
    end

    rsf_shadow_store #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (accept && shadow_we),
        .wr_idx   (cmd_idx),
        .wr_data  (in_data),
        .cmp_idx  (cmd_idx),
        .cmp_data (old_val),
        .rd_idx   (rd_addr),
        .rd_data  (rd_data)
    );

    rsf_decide #(.DATA_W(DATA_W)) u_decide (
        .mode        (mode_q),
        .is_mode_cmd (is_mode_cmd),
        .in_data     (in_data),
        .old_val     (old_val),
        .fwd         (fwd),
        .fwd_data    (fwd_data),
        .shadow_we   (shadow_we),
        .mode_we     (mode_we)
    );

    rsf_outreg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (accept && fwd),
        .ld_addr    (in_addr),
        .ld_data    (fwd_data),
        .out_ready  (out_ready),
        .can_accept (in_ready),
        .out_valid  (out_valid),
        .out_addr   (out_addr),
        .out_data   (out_data)
    );
endmodule

// File: rtl/rsf_checker.sv
// Property checker for the register shadow filter, bound to the top level.
// Assumes inputs are meaningful only on accepted cycles.
module rsf_checker #(
    parameter int              ADDR_W    = 16,
    parameter int              DATA_W    = 32,
    parameter logic [ADDR_W-1:0] MODE_ADDR = 16'hFF00
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic [ADDR_W-1:0] in_addr,
    input logic [DATA_W-1:0] in_data,
    input logic              out_valid,
    input logic              out_ready,
    input logic [ADDR_W-1:0] out_addr,
    input logic [DATA_W-1:0] out_data,
    input logic [1:0]        mode_q,
    input logic [DATA_W-1:0] old_val,
    input logic              shadow_we
);
    logic acc_plain;
    assign acc_plain = in_valid && in_ready && (in_addr != MODE_ADDR);

    // R7: a stalled beat stays put
    p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_data));

    // R1: a matching write in filter mode produces no beat
    p_filter_drop_r1: assert property (@(posedge clk) disable iff (!rst_n)
        acc_plain && mode_q == 2'd0 && in_data == old_val |=> !out_valid);

    // R4: replay sends the stored value
    p_replay_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
        acc_plain && mode_q == 2'd3 |=> out_valid && out_data == $past(old_val)
                                        && out_addr == $past(in_addr));

    // R3: pass mode never writes the shadow
    p_pass_no_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        acc_plain && mode_q == 2'd2 |-> !shadow_we);

    // R6: a mode command sets the mode for the next command
    p_mode_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && in_addr == MODE_ADDR |=> mode_q == $past(in_data[1:0]));

    // R2: track mode forwards the data as given
    p_track_fwd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        acc_plain && mode_q == 2'd1 |=> out_valid && out_data == $past(in_data));
endmodule

bind regshadow_filter rsf_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MODE_ADDR(MODE_ADDR)
) u_rsf_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_addr   (in_addr),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_addr  (out_addr),
    .out_data  (out_data),
    .mode_q    (mode_q),
    .old_val   (old_val),
    .shadow_we (shadow_we)
);

// File: tb/regshadow_filter_bench.sv
// Self-checking bench: vector table walk, then directed handshake, read-port
// and reset tests.
module regshadow_filter_bench;
    localparam logic [15:0] MA = 16'hFF00;

    typedef struct packed {
        logic [15:0] addr;
        logic [31:0] data;
        logic        fwd;
        logic [31:0] odata;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{16'h0010, 32'd0,       1'b0, 32'd0},  // R1/R8 zero shadow, filtered
        '{16'h0010, 32'd5,       1'b1, 32'd5},  // R1 differs, forwarded
        '{16'h0010, 32'd5,       1'b0, 32'd0},  // R1 equal, dropped
        '{MA,       32'd1,       1'b1, 32'd1},  // R6 to track
        '{16'h0010, 32'd5,       1'b1, 32'd5},  // R2 equal still forwarded
        '{16'h0011, 32'd7,       1'b1, 32'd7},  // R2 stored
        '{MA,       32'd2,       1'b1, 32'd2},  // R6 to pass
        '{16'h0011, 32'd9,       1'b1, 32'd9},  // R3 forwarded, not stored
        '{MA,       32'd3,       1'b1, 32'd3},  // R6 to replay
        '{16'h0011, 32'hDEAD,    1'b1, 32'd7},  // R3/R4 stored 7 replayed
        '{16'h0010, 32'h1234,    1'b1, 32'd5},  // R4 data ignored
        '{MA,       32'd0,       1'b1, 32'd0},  // R6 back to filter
        '{16'h0011, 32'd7,       1'b0, 32'd0},  // R4 replay left shadow at 7
        '{16'h0111, 32'd7,       1'b0, 32'd0},  // R9 aliases entry 0x11
        '{16'h0111, 32'd8,       1'b1, 32'd8}   // R9 alias updated
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] in_addr = '0;
    logic [31:0] in_data = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [15:0] out_addr;
    logic [31:0] out_data;
    logic [7:0]  rd_addr = '0;
    logic [31:0] rd_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    regshadow_filter u_regshadow_filter (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_addr(in_addr), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_addr(out_addr), .out_data(out_data),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #40000;
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R8 out_valid in reset", 32'(out_valid), 32'd0);
        chk("R7 in_ready idle", 32'(in_ready), 32'd1);
        rst_n = 1'b1;
        @(negedge clk);

        // Vector walk: drive on a falling edge, check on the next one.
        for (int i = 0; i < NV; i++) begin
            in_valid = 1'b1;
            in_addr  = VECS[i].addr;
            in_data  = VECS[i].data;
            @(negedge clk);
            chk($sformatf("vector %0d out_valid", i), 32'(out_valid), 32'(VECS[i].fwd));
            if (VECS[i].fwd) begin
                chk($sformatf("vector %0d out_data", i), out_data, VECS[i].odata);
                chk($sformatf("vector %0d out_addr", i), 32'(out_addr), 32'(VECS[i].addr));
            end
        end
        in_valid = 1'b0;

        // R5 read port returns shadow contents; R3 pass write left 0x11 alone
        rd_addr = 8'h10;
        @(negedge clk);
        chk("R5 read entry 0x10", rd_data, 32'd5);
        rd_addr = 8'h11;
        @(negedge clk);
        chk("R5/R9 read entry 0x11", rd_data, 32'd8);

        // Switch to track mode
        in_valid = 1'b1; in_addr = MA; in_data = 32'd1;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);

        // R7 backpressure
        out_ready = 1'b0;
        in_valid = 1'b1; in_addr = 16'h0020; in_data = 32'hA;
        @(negedge clk);
        chk("R7 beat appears", 32'(out_valid), 32'd1);
        chk("R7 in_ready low when stalled", 32'(in_ready), 32'd0);
        in_addr = 16'h0021; in_data = 32'hB;
        @(negedge clk);
        chk("R7 beat held", out_data, 32'hA);
        chk("R7 addr held", 32'(out_addr), 32'h20);
        out_ready = 1'b1;
        @(negedge clk);
        chk("R7 next beat after release", out_data, 32'hB);
        chk("R7 next addr", 32'(out_addr), 32'h21);
        in_valid = 1'b0;
        @(negedge clk);
        chk("R7 no beat when idle", 32'(out_valid), 32'd0);

        // R5 same-cycle write and read of entry 0x20 (track mode)
        rd_addr = 8'h20;
        in_valid = 1'b1; in_addr = 16'h0020; in_data = 32'hC;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R5 same-cycle read old", rd_data, 32'hA);
        @(negedge clk);
        chk("R5 read after write", rd_data, 32'hC);

        // R8 reset clears shadow and mode
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R8 rd_data cleared", rd_data, 32'd0);
        chk("R8 no beat after reset", 32'(out_valid), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8 shadow entry cleared", rd_data, 32'd0);
        in_valid = 1'b1; in_addr = 16'h0020; in_data = 32'd0;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R8 mode filter after reset", 32'(out_valid), 32'd0);
        @(negedge clk);
        finish_run();
    end
endmodule